// File: doc/BRIEF.md
# Self-Refresh Entry/Exit Sequencer

This block is the controller-side sequencer that moves a low-power DDR SDRAM into its self-refresh state and later brings it back to normal operation. When the controller asks for entry and every bank is reported idle, the block issues a refresh-style command with the clock-enable pin (CKE) driven low. That cycle registers the entry. From the following cycle onward it deasserts an enable that lets the system stop the memory clock.

While the memory is in self refresh, CKE stays low and the command pins carry a harmless no-operation code. An exit request is acted on only after a programmable minimum residency has elapsed. A request that arrives earlier is remembered. On exit the block first turns the memory clock back on and waits for the clock-stable input. It then raises CKE and issues no-operation commands for a programmable recovery period of at least two cycles. Finally it pulses `ready` for one cycle and returns to idle. The block does not replace periodic auto refresh. Precharge and refresh scheduling stay with the surrounding controller.

Top module: `sr_seq`

## Requirements
- R1: During and directly after reset, `cke` is 1, `cmd` is NOP (4'b0111, bit order {cs_n, ras_n, cas_n, we_n}), `mem_clk_en` is 1 and `ready` is 0.
- R2: An `enter_req` sampled high in idle while `banks_idle` is high produces, in the next cycle, exactly one entry cycle with `cke` = 0, `cmd` = refresh code 4'b0001 and `mem_clk_en` = 1.
- R3: An `enter_req` sampled while `banks_idle` is low is refused: `cke` stays 1, `cmd` stays NOP and `mem_clk_en` stays 1.
- R4: `mem_clk_en` drops in the cycle after the entry cycle, and `cke` is 0 in every cycle where `mem_clk_en` is 0.
- R5: If an exit request (a single-cycle pulse is enough) arrives at or before the residency limit, `mem_clk_en` stays low for exactly max(`trfc_cycles`,1) cycles. If the request arrives in gated cycle i, with cycles counted from 0, and i is later than that limit, the gated period lasts i+1 cycles.
- R6: With no exit request, the block stays in self refresh indefinitely, with `mem_clk_en` = 0 and `cke` = 0.
- R7: On exit, `mem_clk_en` returns to 1 while `cke` is still 0. `cke` rises only in the cycle after `clk_stable` is sampled high. If `clk_stable` first goes high in the k-th such cycle, with k counted from 0, there are k+1 cycles with the clock enabled and `cke` low.
- R8: After `cke` rises, `cmd` is NOP for exactly max(`txsr_cycles`,2) cycles with `ready` low.
- R9: `ready` is then high for exactly one cycle, with `cke` = 1 and `cmd` = NOP. In the next cycle the block is idle and accepts a new entry.
- R10: `exit_req` has no effect in idle and sets no pending exit for a later residency. `enter_req` has no effect in any non-idle state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, always running |
| rst_n | input | 1 | Synchronous active-low reset |
| enter_req | input | 1 | Request to enter self refresh |
| exit_req | input | 1 | Request to leave self refresh; a one-cycle pulse is held pending |
| banks_idle | input | 1 | All banks are precharged and idle |
| clk_stable | input | 1 | Memory clock is running and stable |
| trfc_cycles | input | CNT_W | Minimum residency in cycles |
| txsr_cycles | input | CNT_W | Exit recovery in cycles; values below 2 are treated as 2 |
| cke | output | 1 | Clock-enable pin of the memory |
| cmd | output | 4 | Command pins {cs_n, ras_n, cas_n, we_n} |
| mem_clk_en | output | 1 | Permission to run the memory clock |
| ready | output | 1 | One-cycle pulse: normal commands may resume |

## Verification
The assertions assume that `clk_stable` is meaningful only after the memory clock has been re-enabled. They also assume that the programmed timing inputs stay constant from entry until `ready`. The stimulus changes `trfc_cycles` and `txsr_cycles` only while the block is idle. It raises `clk_stable` only inside the wait window, after a random delay, and clears it before the next entry. Requests are driven on the falling edge. Random runs vary residency, recovery, exit-request timing and clock-stable delay. Directed runs add zero and minimum timing values, refused entries, stray requests and an indefinitely long residency.

// File: rtl/sr_pkg.sv
// Shared types for the self-refresh sequencer.
// Assumes the command bus is ordered {cs_n, ras_n, cas_n, we_n}.
package sr_pkg;

    localparam int CMD_W = 4;

    localparam logic [CMD_W-1:0] CMD_NOP  = 4'b0111;
    localparam logic [CMD_W-1:0] CMD_AREF = 4'b0001;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_ENTER    = 3'd1,
        ST_SR       = 3'd2,
        ST_WAIT_CLK = 3'd3,
        ST_EXIT_NOP = 3'd4,
        ST_READY    = 3'd5
    } sr_state_t;

    typedef struct packed {
        logic             cke;
        logic             clk_en;
        logic             ready;
        logic [CMD_W-1:0] cmd;
    } sr_pins_t;

endpackage

// File: rtl/sr_timer.sv
// Down-counter for a minimum-duration window.
// Loading value V makes 'last' high in the V-th following cycle,
// or in the first following cycle when V is 0 or 1.
// Assumes the caller holds 'load' for at least one cycle before the window.
module sr_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         last
);
    logic [W-1:0] cnt;

    // Load on request, otherwise count down to zero and hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    // The window ends in the cycle in which the count is 1 or 0.
    always_comb last = (cnt <= W'(1));

endmodule

// File: rtl/sr_fsm.sv
// State machine of the self-refresh sequencer.
// It keeps an exit request raised during residency pending until the
// residency timer expires. The timers are loaded from this state.
// Assumes the timer 'last' flags follow sr_timer timing.
module sr_fsm
    import sr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      enter_req,
    input  logic      exit_req,
    input  logic      banks_idle,
    input  logic      clk_stable,
    input  logic      res_last,
    input  logic      xsr_last,
    output sr_state_t state,
    output logic      res_load,
    output logic      xsr_load
);
    sr_state_t nxt;
    logic      exit_pend;

    // Next-state selection.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:     if (enter_req && banks_idle) nxt = ST_ENTER;
            ST_ENTER:    nxt = ST_SR;
            ST_SR:       if (res_last && (exit_pend || exit_req)) nxt = ST_WAIT_CLK;
            ST_WAIT_CLK: if (clk_stable) nxt = ST_EXIT_NOP;
            ST_EXIT_NOP: if (xsr_last) nxt = ST_READY;
            ST_READY:    nxt = ST_IDLE;
            default:     nxt = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Remember an early exit request. Cleared in idle so stray requests never carry over.
    always_ff @(posedge clk) begin
        if (!rst_n || state == ST_IDLE) begin
            exit_pend <= 1'b0;
        end else if (exit_req && (state == ST_ENTER || state == ST_SR)) begin
            exit_pend <= 1'b1;
        end
    end

    // Timer loads: residency from the entry cycle, recovery while waiting for the clock.
    always_comb begin
        res_load = (state == ST_ENTER);
        xsr_load = (state == ST_WAIT_CLK);
    end

endmodule

// File: rtl/sr_pin_dec.sv
// Decodes the sequencer state into the memory-side pin values.
// Purely combinational from the state register, so the pins are free of glitches from the inputs.
module sr_pin_dec
    import sr_pkg::*;
(
    input  sr_state_t state,
    output sr_pins_t  pins
);
    // Per-state pin table.
    always_comb begin
        pins = '{cke: 1'b1, clk_en: 1'b1, ready: 1'b0, cmd: CMD_NOP};
        unique case (state)
            ST_IDLE:     ;
            ST_ENTER:    begin pins.cke = 1'b0; pins.cmd = CMD_AREF; end
            ST_SR:       begin pins.cke = 1'b0; pins.clk_en = 1'b0; end
            ST_WAIT_CLK: pins.cke = 1'b0;
            ST_EXIT_NOP: ;
            ST_READY:    pins.ready = 1'b1;
            default:     ;
        endcase
    end

endmodule

// File: rtl/sr_seq.sv
// Top of the self-refresh entry/exit sequencer.
// Drives CKE, the command bus and a memory clock enable. It enforces the
// minimum residency and the exit recovery period.
// Assumes trfc_cycles and txsr_cycles are stable from entry until ready.
module sr_seq
    import sr_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enter_req,
    input  logic             exit_req,
    input  logic             banks_idle,
    input  logic             clk_stable,
    input  logic [CNT_W-1:0] trfc_cycles,
    input  logic [CNT_W-1:0] txsr_cycles,
    output logic             cke,
    output logic [CMD_W-1:0] cmd,
    output logic             mem_clk_en,
    output logic             ready
);
    localparam int                NTIM    = 2;
    localparam int                T_RES   = 0;
    localparam int                T_XSR   = 1;
    localparam logic [CNT_W-1:0]  XSR_MIN = CNT_W'(2);

    sr_state_t        state;
    sr_pins_t         pins;
    logic [NTIM-1:0]  tim_load;
    logic [NTIM-1:0]  tim_last;
    logic [CNT_W-1:0] tim_val [NTIM];

    // Recovery length is raised to the two-cycle floor.
    always_comb begin
        tim_val[T_RES] = trfc_cycles;
        tim_val[T_XSR] = (txsr_cycles < XSR_MIN) ? XSR_MIN : txsr_cycles;
    end

    sr_fsm fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .enter_req  (enter_req),
        .exit_req   (exit_req),
        .banks_idle (banks_idle),
        .clk_stable (clk_stable),
        .res_last   (tim_last[T_RES]),
        .xsr_last   (tim_last[T_XSR]),
        .state      (state),
        .res_load   (tim_load[T_RES]),
        .xsr_load   (tim_load[T_XSR])
    );

    for (genvar g = 0; g < NTIM; g++) begin : g_tim
        sr_timer #(.W(CNT_W)) tim_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (tim_load[g]),
            .load_val (tim_val[g]),
            .last     (tim_last[g])
        );
    end

    sr_pin_dec dec_i (
        .state (state),
        .pins  (pins)
    );

    // Output pin mapping.
    always_comb begin
        cke        = pins.cke;
        cmd        = pins.cmd;
        mem_clk_en = pins.clk_en;
        ready      = pins.ready;
    end

endmodule

// File: rtl/sr_seq_chk.sv
// Port-level protocol checker for sr_seq, attached with bind.
// Assumes clk_stable is meaningful only while the memory clock is enabled.
module sr_seq_chk
    import sr_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             enter_req,
    input logic             banks_idle,
    input logic             clk_stable,
    input logic             cke,
    input logic [CMD_W-1:0] cmd,
    input logic             mem_clk_en,
    input logic             ready
);
    AST_ENTRY_GUARDED:  assert property (@(posedge clk) disable iff (!rst_n) $fell(cke) |-> $past(enter_req) && $past(banks_idle)); // R3
    AST_ENTRY_CMD:      assert property (@(posedge clk) disable iff (!rst_n) $fell(cke) |-> cmd == CMD_AREF && mem_clk_en); // R2
    AST_GATE_AFTER:     assert property (@(posedge clk) disable iff (!rst_n) $fell(cke) |=> !mem_clk_en); // R4
    AST_CKE_LOW_GATED:  assert property (@(posedge clk) disable iff (!rst_n) !mem_clk_en |-> !cke); // R4
    AST_CKE_RISE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n) $rose(cke) |-> $past(clk_stable) && $past(mem_clk_en)); // R7
    AST_EXIT_NOP:       assert property (@(posedge clk) disable iff (!rst_n) $rose(cke) |-> cmd == CMD_NOP && !ready); // R8
    AST_READY_MIN_TWO:  assert property (@(posedge clk) disable iff (!rst_n) ready |-> $past(cke, 1) && $past(cke, 2)); // R8
    AST_READY_PULSE:    assert property (@(posedge clk) disable iff (!rst_n) ready |=> !ready && cke); // R9
endmodule

bind sr_seq sr_seq_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .enter_req  (enter_req),
    .banks_idle (banks_idle),
    .clk_stable (clk_stable),
    .cke        (cke),
    .cmd        (cmd),
    .mem_clk_en (mem_clk_en),
    .ready      (ready)
);

// File: tb/sr_seq_tb.sv
// Self-checking bench for sr_seq: random full cycles plus directed corner cases.
module sr_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 8;
    localparam logic [3:0] NOP  = 4'b0111;
    localparam logic [3:0] AREF = 4'b0001;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enter_req = 1'b0, exit_req = 1'b0, banks_idle = 1'b0, clk_stable = 1'b0;
    logic [CNT_W-1:0] trfc_cycles = '0, txsr_cycles = '0;
    logic cke, mem_clk_en, ready;
    logic [3:0] cmd;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sr_seq #(.CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .enter_req(enter_req), .exit_req(exit_req),
        .banks_idle(banks_idle), .clk_stable(clk_stable),
        .trfc_cycles(trfc_cycles), .txsr_cycles(txsr_cycles),
        .cke(cke), .cmd(cmd), .mem_clk_en(mem_clk_en), .ready(ready)
    );

    function automatic int exp_gated(int trfc, int exd);
        int base = (trfc < 1) ? 1 : trfc;
        return (exd + 1 > base) ? exd + 1 : base;
    endfunction

    function automatic int exp_xsr(int txsr);
        return (txsr < 2) ? 2 : txsr;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle_outputs(input string req);
        check(cke == 1'b1, {req, " cke"}, int'(cke), 1);
        check(cmd == NOP, {req, " cmd"}, int'(cmd), int'(NOP));
        check(mem_clk_en == 1'b1, {req, " clk_en"}, int'(mem_clk_en), 1);
        check(ready == 1'b0, {req, " ready"}, int'(ready), 0);
    endtask

    // One full entry/residency/exit cycle; called at a negedge with the DUT idle.
    task automatic run_cycle(input int trfc, input int txsr, input int exd, input int sd, input bit noise);
        int i, w, n;
        trfc_cycles = CNT_W'(trfc);
        txsr_cycles = CNT_W'(txsr);
        clk_stable  = 1'b0;
        banks_idle  = 1'b1;
        enter_req   = 1'b1;
        @(negedge clk);
        check(cke == 1'b0 && cmd == AREF && mem_clk_en == 1'b1, "R2 entry cycle", int'({cke, cmd, mem_clk_en}), int'({1'b0, AREF, 1'b1}));
        enter_req = noise;  // R10: held request has no effect outside idle
        @(negedge clk);
        i = 0;
        while (!mem_clk_en && i < 400) begin
            check(cke == 1'b0, "R4 cke low while gated", int'(cke), 0);
            exit_req = (i == exd);
            i++;
            @(negedge clk);
        end
        exit_req = 1'b0;
        check(i == exp_gated(trfc, exd), (exd > 40) ? "R6 stays in self refresh" : "R5 residency", i, exp_gated(trfc, exd));
        w = 0;
        while (mem_clk_en && !cke && w < 400) begin
            clk_stable = (w >= sd);
            w++;
            @(negedge clk);
        end
        check(w == sd + 1, "R7 clock-stable wait", w, sd + 1);
        n = 0;
        while (cke && !ready && n < 400) begin
            check(cmd == NOP, "R8 recovery NOP", int'(cmd), int'(NOP));
            n++;
            @(negedge clk);
        end
        check(n == exp_xsr(txsr), "R8 recovery length", n, exp_xsr(txsr));
        check(ready == 1'b1 && cke == 1'b1 && cmd == NOP, "R9 ready pulse", int'({ready, cke, cmd}), int'({2'b11, NOP}));
        enter_req  = 1'b0;
        clk_stable = 1'b0;
        @(negedge clk);
        idle_outputs("R9 back to idle");
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        idle_outputs("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        idle_outputs("R1 after reset");

        // R3: entry refused while banks busy
        banks_idle = 1'b0;
        enter_req  = 1'b1;
        repeat (5) begin
            @(negedge clk);
            idle_outputs("R3 refused entry");
        end
        enter_req = 1'b0;

        // R10: stray exit in idle is ignored and not carried into the next residency
        exit_req = 1'b1;
        @(negedge clk);
        exit_req = 1'b0;
        idle_outputs("R10 exit in idle");
        @(negedge clk);
        run_cycle(3, 4, 60, 0, 1'b0);  // R6 long residency, no pending exit

        // Directed corners
        run_cycle(0, 0, 0, 0, 1'b0);   // R5 zero residency, R8 floor
        run_cycle(1, 1, 0, 2, 1'b0);
        run_cycle(2, 2, 5, 0, 1'b1);   // late exit, R10 enter noise
        run_cycle(12, 3, 0, 1, 1'b1);  // early pulse held pending

        // Constrained random cycles
        for (int k = 0; k < 25; k++) begin
            run_cycle(int'($urandom_range(0, 20)), int'($urandom_range(0, 10)),
                      int'($urandom_range(0, 25)), int'($urandom_range(0, 4)),
                      1'($urandom_range(0, 1)));
            repeat (int'($urandom_range(0, 3))) begin
                @(negedge clk);
                idle_outputs("R9 idle gap");
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule